// File: doc/BRIEF.md
# Debug Status Flag Register

This block holds the sticky status flags of a debug and system-service unit, reached over a simple single-cycle register port. Hardware event pulses set the flags: an operation finished, an operation failed, a bus error was seen, an illegal access was made, and, for each CPU, a debugger cold-plug that extends that CPU's reset phase and boot-code phase. Software clears a flag by writing 1 to its bit. Writing 0 leaves the flag alone.

On a read, the per-CPU extension flags are shaped by the CPU presence inputs and the access-point disable input. The stored state itself is never changed by this. The register port also checks itself. A write while write protection is asserted is blocked. An access to an offset with no register behind it is an illegal access. A command write with a code outside the legal range is also illegal. Each of these sets the protection-error flag. Legal command writes are passed on as a one-cycle strobe with the command code.

Top module: `dsr_status_top`

## Requirements
- R1: After synchronous reset every stored flag is 0, so a status read with every CPU present and access-point disable low returns 0x00000000.
- R2: A pulse on the done, failure or bus-error event input sets status bit 0, bit 1 or bit 2 at the next clock edge. The bit stays set until software clears it.
- R3: A cold-plug pulse for CPU x sets both the reset-extension flag at status bit 8+x and the boot-extension flag at status bit 16+x at the next clock edge.
- R4: A write to the status offset (0x100) clears each implemented bit written as 1 and leaves each bit written as 0 unchanged. Bits 4-7, 10-15 and 18-31 always read 0.
- R5: If a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R6: While CPU x is absent (its presence input is 0), status bits 8+x and 16+x read as 1, whatever their stored value.
- R7: While CPU x is present and access-point disable is high, status bits 8+x and 16+x read as 0. When the disable drops, the stored values read back unchanged.
- R8: While write protection is high, a write to any offset changes no flag except the protection-error flag, which it sets. Such a write produces no command strobe.
- R9: A read or write to any offset other than 0x000 (command) or 0x100 (status) sets the protection-error flag (status bit 3) and reads 0.
- R10: A write to offset 0x000 carries a command code in write-data bits [3:0]. Codes 0-7 raise cmd_strobe in the same cycle, with cmd_code equal to the code, and do not set the error flag. Codes 8-15 give no strobe and set the protection-error flag.
- R11: Read data is combinational in the cycle of the read strobe and shows the state from before that cycle's events. Reads at offset 0x000 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| wr_protect | input | 1 | Blocks all writes while high |
| ev_op_done | input | 1 | Operation-complete pulse |
| ev_op_fail | input | 1 | Operation-failure pulse |
| ev_bus_err | input | 1 | Bus-error pulse |
| ev_coldplug | input | 2 | Per-CPU debugger cold-plug pulse |
| cpu_present | input | 2 | Per-CPU presence |
| ap_disable | input | 1 | Access-point disable, masks extension flags on read |
| cmd_strobe | output | 1 | One-cycle pulse for a legal command write |
| cmd_code | output | 4 | Command code written |

## Verification
A flag stored wrongly shows up at the next status read after the cycle in which it went wrong. The bench reads status in every idle cycle, so any wrongly set or lost bit shows within one clock. A fault in the read-time overrides appears at once, in the same read cycle. The bench then drops the override and reads again, which exposes any fault where an override leaked into the stored state. Faults in the command decode show in the same cycle on cmd_strobe, and at the next status read through the error flag.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int unsigned DSR_NCPU  = 2;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CRST_BASE = 8;
    localparam int unsigned BOOT_BASE = 16;

    // Packed so bit 0 is the done flag, bit 3 the protection-error flag.
    typedef struct packed {
        logic [DSR_NCPU-1:0] boot_ext;
        logic [DSR_NCPU-1:0] rst_ext;
        logic                perr;
        logic                berr;
        logic                fail;
        logic                done;
    } dsr_flags_t;

    localparam int unsigned FLAG_W = $bits(dsr_flags_t);

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_CMD    = 2'd2,
        ACC_BAD    = 2'd3
    } dsr_target_e;

    function automatic logic [DATA_W-1:0] flags_to_word(input dsr_flags_t f);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = f.done;
        w[1] = f.fail;
        w[2] = f.berr;
        w[3] = f.perr;
        for (int i = 0; i < DSR_NCPU; i++) begin
            w[CRST_BASE+i] = f.rst_ext[i];
            w[BOOT_BASE+i] = f.boot_ext[i];
        end
        return w;
    endfunction

    function automatic dsr_flags_t word_to_flags(input logic [DATA_W-1:0] w);
        dsr_flags_t f;
        f.done = w[0];
        f.fail = w[1];
        f.berr = w[2];
        f.perr = w[3];
        for (int i = 0; i < DSR_NCPU; i++) begin
            f.rst_ext[i]  = w[CRST_BASE+i];
            f.boot_ext[i] = w[BOOT_BASE+i];
        end
        return f;
    endfunction

    // Read-time shaping of the per-CPU flags; stored state is untouched.
    function automatic dsr_flags_t apply_view(input dsr_flags_t f,
                                              input logic [DSR_NCPU-1:0] present,
                                              input logic ap_dis);
        dsr_flags_t v;
        v = f;
        for (int i = 0; i < DSR_NCPU; i++) begin
            if (!present[i]) begin
                v.rst_ext[i]  = 1'b1;
                v.boot_ext[i] = 1'b1;
            end else if (ap_dis) begin
                v.rst_ext[i]  = 1'b0;
                v.boot_ext[i] = 1'b0;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/dsr_bus_decode.sv
module dsr_bus_decode
    import dsr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h100,
    parameter logic [ADDR_W-1:0] CMD_OFS  = 12'h000,
    parameter int unsigned CMD_W    = 4,
    parameter int unsigned CMD_MAX  = 7
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wp,
    output dsr_target_e       target,
    output dsr_flags_t        clr_mask,
    output logic              perr_evt,
    output logic              cmd_fire,
    output logic [CMD_W-1:0]  cmd_val
);

    logic             wr_ok;
    logic             cmd_bad;
    logic [CMD_W-1:0] code;

    always_comb begin
        if (!sel)                  target = ACC_NONE;
        else if (addr == STAT_OFS) target = ACC_STATUS;
        else if (addr == CMD_OFS)  target = ACC_CMD;
        else                       target = ACC_BAD;
    end

    assign code    = wdata[CMD_W-1:0];
    assign wr_ok   = sel && wr && !wp;
    assign cmd_bad = wr_ok && (target == ACC_CMD) && (int'(code) > CMD_MAX);

    assign clr_mask = (wr_ok && target == ACC_STATUS) ? word_to_flags(wdata) : '0;
    assign perr_evt = (target == ACC_BAD) || (sel && wr && wp) || cmd_bad;
    assign cmd_fire = wr_ok && (target == ACC_CMD) && !cmd_bad;
    assign cmd_val  = code;

endmodule

// File: rtl/dsr_flag_bank.sv
module dsr_flag_bank #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)             q[i] <= 1'b0;
            else if (set_vec[i]) q[i] <= 1'b1;
            else if (clr_vec[i]) q[i] <= 1'b0;
        end

        a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> q[i]);
        a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !q[i]);
        a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
            (!set_vec[i] && !clr_vec[i]) |=> $stable(q[i]));
    end

endmodule

// File: rtl/dsr_read_view.sv
module dsr_read_view
    import dsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  dsr_target_e         target,
    input  logic                rd,
    input  dsr_flags_t          stored,
    input  logic [DSR_NCPU-1:0] present,
    input  logic                ap_dis,
    output logic [DATA_W-1:0]   rdata
);

    dsr_flags_t shown;

    assign shown = apply_view(stored, present, ap_dis);
    assign rdata = (rd && target == ACC_STATUS) ? flags_to_word(shown) : '0;

    for (genvar x = 0; x < DSR_NCPU; x++) begin : g_chk
        a_r6_absent_reads_one: assert property (@(posedge clk) disable iff (rst)
            (rd && target == ACC_STATUS && !present[x])
                |-> (rdata[CRST_BASE+x] && rdata[BOOT_BASE+x]));
        a_r7_disable_reads_zero: assert property (@(posedge clk) disable iff (rst)
            (rd && target == ACC_STATUS && present[x] && ap_dis)
                |-> (!rdata[CRST_BASE+x] && !rdata[BOOT_BASE+x]));
    end

endmodule

// File: rtl/dsr_status_top.sv
module dsr_status_top
    import dsr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h100,
    parameter logic [ADDR_W-1:0] CMD_OFS  = 12'h000,
    parameter int unsigned CMD_W    = 4,
    parameter int unsigned CMD_MAX  = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                wr_protect,
    input  logic                ev_op_done,
    input  logic                ev_op_fail,
    input  logic                ev_bus_err,
    input  logic [DSR_NCPU-1:0] ev_coldplug,
    input  logic [DSR_NCPU-1:0] cpu_present,
    input  logic                ap_disable,
    output logic                cmd_strobe,
    output logic [CMD_W-1:0]    cmd_code
);

    dsr_target_e target;
    dsr_flags_t  clr_mask;
    dsr_flags_t  set_mask;
    dsr_flags_t  stored;
    logic        perr_evt;
    logic [FLAG_W-1:0] q_vec;

    dsr_bus_decode #(
        .ADDR_W  (ADDR_W),
        .STAT_OFS(STAT_OFS),
        .CMD_OFS (CMD_OFS),
        .CMD_W   (CMD_W),
        .CMD_MAX (CMD_MAX)
    ) u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .wp      (wr_protect),
        .target  (target),
        .clr_mask(clr_mask),
        .perr_evt(perr_evt),
        .cmd_fire(cmd_strobe),
        .cmd_val (cmd_code)
    );

    always_comb begin
        set_mask          = '0;
        set_mask.done     = ev_op_done;
        set_mask.fail     = ev_op_fail;
        set_mask.berr     = ev_bus_err;
        set_mask.perr     = perr_evt;
        set_mask.rst_ext  = ev_coldplug;
        set_mask.boot_ext = ev_coldplug;
    end

    dsr_flag_bank #(.WIDTH(FLAG_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_mask),
        .clr_vec(clr_mask),
        .q      (q_vec)
    );

    assign stored = dsr_flags_t'(q_vec);

    dsr_read_view u_view (
        .clk    (clk),
        .rst    (rst),
        .target (target),
        .rd     (!bus_wr),
        .stored (stored),
        .present(cpu_present),
        .ap_dis (ap_disable),
        .rdata  (bus_rdata)
    );

    a_r8_protected_write_flags: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && wr_protect) |=> stored.perr);
    a_r8_protected_no_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_protect |-> !cmd_strobe);
    a_r9_bad_offset_flags: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr != STAT_OFS && bus_addr != CMD_OFS) |=> stored.perr);
    a_r10_strobe_code_legal: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> (int'(cmd_code) <= CMD_MAX));
    a_r3_coldplug_both: assert property (@(posedge clk) disable iff (rst)
        (ev_coldplug != '0) |=> ((stored.rst_ext & $past(ev_coldplug)) == $past(ev_coldplug)
                                 && (stored.boot_ext & $past(ev_coldplug)) == $past(ev_coldplug)));

endmodule

// File: tb/dsr_status_top_tb_top.sv
module dsr_status_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wr_protect;
    logic        ev_op_done, ev_op_fail, ev_bus_err;
    logic [1:0]  ev_coldplug;
    logic [1:0]  cpu_present;
    logic        ap_disable;
    logic        cmd_strobe;
    logic [3:0]  cmd_code;

    int checks   = 0;
    int failures = 0;
    logic [31:0] m_stat;

    always #2 clk = ~clk;

    dsr_status_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wr_protect(wr_protect), .ev_op_done(ev_op_done), .ev_op_fail(ev_op_fail),
        .ev_bus_err(ev_bus_err), .ev_coldplug(ev_coldplug), .cpu_present(cpu_present),
        .ap_disable(ap_disable), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
    );

    function automatic logic [31:0] view(input logic [31:0] s);
        logic [31:0] v = s;
        for (int x = 0; x < 2; x++) begin
            if (!cpu_present[x]) begin v[8+x] = 1; v[16+x] = 1; end
            else if (ap_disable) begin v[8+x] = 0; v[16+x] = 0; end
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, compare before the rising edge, advance the model.
    task automatic step(input logic sel, input logic wr, input logic [11:0] addr,
                        input logic [31:0] wd, input string req);
        logic [31:0] exp_rd, setm, clrm;
        logic        legal, exp_stb, perr;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        #1;
        legal   = (addr == 12'h100) || (addr == 12'h000);
        exp_rd  = (sel && !wr && addr == 12'h100) ? view(m_stat) : 32'h0;
        exp_stb = sel && wr && !wr_protect && addr == 12'h000 && wd[3:0] <= 4'd7;
        perr    = sel && (!legal || (wr && wr_protect) ||
                  (wr && !wr_protect && addr == 12'h000 && wd[3:0] > 4'd7));
        if (sel && !wr) check(req, bus_rdata, exp_rd, "rdata");
        check(req, {31'b0, cmd_strobe}, {31'b0, exp_stb}, "cmd_strobe");
        if (exp_stb) check(req, {28'b0, cmd_code}, {28'b0, wd[3:0]}, "cmd_code");
        setm = 32'h0;
        setm[0] = ev_op_done; setm[1] = ev_op_fail; setm[2] = ev_bus_err; setm[3] = perr;
        setm[9:8] = ev_coldplug; setm[17:16] = ev_coldplug;
        clrm = (sel && wr && !wr_protect && addr == 12'h100) ? (wd & 32'h0003_030F) : 32'h0;
        m_stat = (m_stat & ~clrm) | setm;
        @(posedge clk);
        #0.5;
        ev_op_done = 0; ev_op_fail = 0; ev_bus_err = 0; ev_coldplug = 0;
    endtask

    task automatic rd_stat(input string req);
        step(1, 0, 12'h100, 32'h0, req);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        wr_protect = 0; ev_op_done = 0; ev_op_fail = 0; ev_bus_err = 0;
        ev_coldplug = 0; cpu_present = 2'b11; ap_disable = 0; m_stat = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        rd_stat("R1");                                   // reset value 0
        ev_op_done = 1; rd_stat("R11");                  // same-cycle read shows old state
        rd_stat("R2");
        ev_op_fail = 1; ev_bus_err = 1; step(0, 0, 0, 0, "R2");
        rd_stat("R2");
        ev_coldplug = 2'b01; rd_stat("R3");
        rd_stat("R3");
        ev_coldplug = 2'b10; rd_stat("R3");
        rd_stat("R3");
        step(1, 1, 12'h100, 32'h0, "R4");                // writing 0 changes nothing
        rd_stat("R4");
        step(1, 1, 12'h100, 32'h0000_0101, "R4");
        rd_stat("R4");
        ev_op_fail = 1; step(1, 1, 12'h100, 32'h0000_0002, "R5");
        rd_stat("R5");
        step(1, 1, 12'h100, 32'hFFFF_FFFF, "R4");
        rd_stat("R4");
        ev_coldplug = 2'b11; rd_stat("R3");
        step(1, 1, 12'h100, 32'h0001_0100, "R4");        // clear CPU0 bits, CPU1 stays
        cpu_present = 2'b10; rd_stat("R6");              // CPU0 absent reads 1
        cpu_present = 2'b01; rd_stat("R6");
        cpu_present = 2'b11; ap_disable = 1; rd_stat("R7");
        cpu_present = 2'b10; rd_stat("R7");              // absence beats disable
        cpu_present = 2'b11; ap_disable = 0; rd_stat("R7"); // stored values intact
        wr_protect = 1;
        step(1, 1, 12'h100, 32'hFFFF_FFFF, "R8");
        step(1, 1, 12'h000, 32'h0000_0003, "R8");
        rd_stat("R8");
        wr_protect = 0;
        step(1, 1, 12'h100, 32'hFFFF_FFFF, "R4");
        rd_stat("R9");
        step(1, 0, 12'h104, 32'h0, "R9");
        rd_stat("R9");
        step(1, 1, 12'h100, 32'h0000_0008, "R9");
        step(1, 1, 12'h200, 32'hFFFF_FFFF, "R9");
        rd_stat("R9");
        step(1, 1, 12'h100, 32'h0000_0008, "R10");
        step(1, 1, 12'h000, 32'h0000_0005, "R10");
        step(1, 1, 12'h000, 32'h0000_0007, "R10");
        step(1, 1, 12'h000, 32'h0000_0000, "R10");
        rd_stat("R10");
        step(1, 1, 12'h000, 32'h0000_0009, "R10");
        rd_stat("R10");
        step(1, 0, 12'h000, 32'h0, "R11");               // command offset reads 0
        for (int k = 0; k < 20; k++) begin
            ev_op_done = k[0]; ev_coldplug = k[2:1]; cpu_present = ~k[4:3];
            if (k[1]) step(1, 1, 12'h100, 32'h0003_030F ^ {k[7:0], k[7:0], k[7:0], k[7:0]}, "R5");
            else      rd_stat("R6");
        end
        cpu_present = 2'b11;
        rd_stat("R4");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule